// File: doc/BRIEF.md
# Row-Buffered DRAM Read/Write Controller

This block connects a processor-side request port to a small DRAM array of 4 rows by 4 columns of 8-bit supercells. Each request carries a 4-bit address. The controller splits that address into a row index and a column index and sends both over one shared 2-bit address bus, the row first and the column later. A row strobe copies the whole row from the array into an internal row buffer. A column strobe then picks one supercell out of that buffer and sends it to the data lines. A write sends its column address first and its data byte in the following cycle, and the byte goes into the row buffer.

The controller remembers which row is open and whether any row is open. A request to the open row issues only a column strobe. A request to another row first closes the open row by writing the buffer back into the array, then issues a row strobe for the new row. The array model and its row buffer are part of the design, so the whole path can be observed from the ports. The strobe and address-bus signals are brought out as ports for that reason.

Top module: `dramc_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `mem_ras`, `mem_cas` and `mem_wb` are all 0. No row is open, so the first request always issues a row strobe.
- R2: The request address splits as row = `req_addr[3:2]` and column = `req_addr[1:0]`. `mem_addr` carries the row index in the row-strobe cycle, the column index in the column-strobe cycle, and the row being closed in the write-back cycle.
- R3: With no row open, an accepted request drives the row strobe in cycle 1 after acceptance and the column strobe in cycle 3. `resp_valid` rises in cycle 5. Each gap is 2 cycles.
- R4: A request to the open row issues no row strobe and no write-back. Its column strobe comes in cycle 1 and its response in cycle 3.
- R5: A request to a row other than the open one drives `mem_wb` in cycle 1, the row strobe in cycle 2 and the column strobe in cycle 4. Its response comes in cycle 6.
- R6: A read returns the stored supercell. After reset, the supercell at address a holds (29*a + 5) mod 256.
- R7: A write presents its column in the strobe cycle and its data byte in the next cycle. The write's response carries the written byte, and later reads of that address return it.
- R8: Data written into the row buffer is written back to the array when the row is closed, so it is still there after another row has been opened and the first row opened again.
- R9: While `resp_valid` is 1 and `resp_ready` is 0, the response stays valid and `resp_data` does not change.
- R10: In the cycle a response is taken, the controller can accept a new request. A back-to-back hit then responds 3 cycles after that cycle.
- R11: No more than one of `mem_ras`, `mem_cas`, `mem_wb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 4 | Supercell address, row in upper 2 bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Requester takes the response |
| resp_data | output | 8 | Read byte, or the written byte for a write |
| mem_addr | output | 2 | Shared row/column address bus to the array |
| mem_ras | output | 1 | Row strobe |
| mem_cas | output | 1 | Column strobe |
| mem_wb | output | 1 | Row-buffer write-back (row close) strobe |

## Verification
Two events can happen in the same clock edge: a pending response is handed off, and the next request is accepted. To make this happen, the bench raises a second request while the first one is still being served and holds `resp_ready` high. The second request is then taken in the cycle the first response leaves. The bench checks three things: the first response's data, `req_ready` in that cycle, and that the second response appears exactly three cycles later with the right byte. Back-pressure on the response is tested separately, by holding the data stable over several stalled cycles.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    localparam int ROWS   = 4;
    localparam int COLS   = 4;
    localparam int DATA_W = 8;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CL,
        ST_RESP
    } ctrl_state_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } pend_req_t;

    // Power-up contents of the array: linear address a holds 29*a + 5.
    function automatic logic [DATA_W-1:0] seed_value(input int unsigned idx);
        return DATA_W'(idx * 29 + 5);
    endfunction

    function automatic logic [ROW_W-1:0] addr_row(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: ROW_W];
    endfunction

    function automatic logic [COL_W-1:0] addr_col(input logic [ADDR_W-1:0] a);
        return a[COL_W-1:0];
    endfunction

endpackage

// File: rtl/dramc_array.sv
module dramc_array
    import dramc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ras,
    input  logic              cas,
    input  logic              wb,
    input  logic              wr_phase,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] cells  [ROWS][COLS];
    logic [DATA_W-1:0] rowbuf [COLS];
    logic [COL_W-1:0]  col_q;

    logic [ROW_W-1:0] bus_row;
    logic [COL_W-1:0] bus_col;
    assign bus_row = bus_addr[ROW_W-1:0];
    assign bus_col = bus_addr[COL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    cells[r][c] <= seed_value(r * COLS + c);
                end
            end
            for (int c = 0; c < COLS; c++) begin
                rowbuf[c] <= '0;
            end
            col_q <= '0;
            dout  <= '0;
        end else begin
            // Row strobe: copy the addressed row into the row buffer.
            if (ras) begin
                for (int c = 0; c < COLS; c++) begin
                    rowbuf[c] <= cells[bus_row][c];
                end
            end
            // Row close: write the buffer back into the addressed row.
            if (wb) begin
                for (int c = 0; c < COLS; c++) begin
                    cells[bus_row][c] <= rowbuf[c];
                end
            end
            // Column strobe: latch the column and drive the supercell out.
            if (cas) begin
                col_q <= bus_col;
                dout  <= rowbuf[bus_col];
            end
            // Data phase of a write lands in the row buffer.
            if (wr_phase) begin
                rowbuf[col_q] <= din;
            end
        end
    end

endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
    import dramc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [DATA_W-1:0] resp_data,
    output logic [BUS_W-1:0]  mem_addr,
    output logic              mem_ras,
    output logic              mem_cas,
    output logic              mem_wb,
    output logic              mem_wr_phase,
    output logic [DATA_W-1:0] mem_din,
    input  logic [DATA_W-1:0] mem_dout
);

    ctrl_state_e       state;
    pend_req_t         cur;
    logic              open_valid;
    logic [ROW_W-1:0]  open_row;
    logic [DATA_W-1:0] resp_q;

    logic              accept;
    ctrl_state_e       dispatch;
    logic [ROW_W-1:0]  in_row;

    assign in_row    = addr_row(req_addr);
    assign req_ready = (state == ST_IDLE) || (state == ST_RESP && resp_ready);
    assign accept    = req_valid && req_ready;

    always_comb begin
        if (open_valid && open_row == in_row) begin
            dispatch = ST_COL;
        end else if (open_valid) begin
            dispatch = ST_CLOSE;
        end else begin
            dispatch = ST_ROW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            open_valid <= 1'b0;
            open_row   <= '0;
            resp_q     <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_RESP: begin
                    if (accept) begin
                        cur.row   <= in_row;
                        cur.col   <= addr_col(req_addr);
                        cur.we    <= req_we;
                        cur.wdata <= req_wdata;
                        state     <= dispatch;
                    end else if (state == ST_RESP && resp_ready) begin
                        state <= ST_IDLE;
                    end
                end
                ST_CLOSE: state <= ST_ROW;
                ST_ROW: begin
                    open_valid <= 1'b1;
                    open_row   <= cur.row;
                    state      <= ST_RCD;
                end
                ST_RCD: state <= ST_COL;
                ST_COL: state <= ST_CL;
                ST_CL: begin
                    resp_q <= cur.we ? cur.wdata : mem_dout;
                    state  <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_CLOSE: mem_addr = BUS_W'(open_row);
            ST_ROW:   mem_addr = BUS_W'(cur.row);
            ST_COL:   mem_addr = BUS_W'(cur.col);
            default:  mem_addr = '0;
        endcase
    end

    assign mem_ras      = (state == ST_ROW);
    assign mem_cas      = (state == ST_COL);
    assign mem_wb       = (state == ST_CLOSE);
    assign mem_wr_phase = (state == ST_CL) && cur.we;
    assign mem_din      = cur.wdata;
    assign resp_valid   = (state == ST_RESP);
    assign resp_data    = resp_q;

endmodule

// File: rtl/dramc_top.sv
module dramc_top
    import dramc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [DATA_W-1:0] resp_data,
    output logic [BUS_W-1:0]  mem_addr,
    output logic              mem_ras,
    output logic              mem_cas,
    output logic              mem_wb
);

    logic              wr_phase;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] dout;

    dramc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_we       (req_we),
        .req_wdata    (req_wdata),
        .resp_valid   (resp_valid),
        .resp_ready   (resp_ready),
        .resp_data    (resp_data),
        .mem_addr     (mem_addr),
        .mem_ras      (mem_ras),
        .mem_cas      (mem_cas),
        .mem_wb       (mem_wb),
        .mem_wr_phase (wr_phase),
        .mem_din      (din),
        .mem_dout     (dout)
    );

    dramc_array u_array (
        .clk      (clk),
        .rst      (rst),
        .ras      (mem_ras),
        .cas      (mem_cas),
        .wb       (mem_wb),
        .wr_phase (wr_phase),
        .bus_addr (mem_addr),
        .din      (din),
        .dout     (dout)
    );

endmodule

// File: rtl/dramc_checker.sv
module dramc_checker
    import dramc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_ras,
    input logic              mem_cas,
    input logic              mem_wb,
    input logic              resp_valid,
    input logic              resp_ready,
    input logic [DATA_W-1:0] resp_data
);

    p_row_to_col_r3: assert property (@(posedge clk) disable iff (rst)
        mem_ras |-> ##2 mem_cas);

    p_col_to_data_r3: assert property (@(posedge clk) disable iff (rst)
        mem_cas |-> ##2 resp_valid);

    p_close_then_row_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wb |=> mem_ras);

    p_resp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_ras, mem_cas, mem_wb}));

endmodule

bind dramc_top dramc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_ras    (mem_ras),
    .mem_cas    (mem_cas),
    .mem_wb     (mem_wb),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_data  (resp_data)
);

// File: tb/dramc_top_tb.sv
module dramc_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_ready;
    logic [3:0] req_addr;
    logic       req_we;
    logic [7:0] req_wdata;
    logic       resp_valid;
    logic       resp_ready;
    logic [7:0] resp_data;
    logic [1:0] mem_addr;
    logic       mem_ras;
    logic       mem_cas;
    logic       mem_wb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench-side model: flat contents and open-row tracking.
    logic [7:0] m_mem [16];
    bit         m_open;
    logic [1:0] m_row;

    always #2 clk = ~clk;

    dramc_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_ready (resp_ready),
        .resp_data  (resp_data),
        .mem_addr   (mem_addr),
        .mem_ras    (mem_ras),
        .mem_cas    (mem_cas),
        .mem_wb     (mem_wb)
    );

    task automatic chk(input string r, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    // One request; records strobe cycles relative to acceptance.
    task automatic do_req(input logic [3:0] a, input logic we, input logic [7:0] wd,
                          input int hold, input string dtag);
        int exp_wb, exp_ras, exp_cas, exp_lat;
        int got_wb = 0, got_ras = 0, got_cas = 0, got_lat = 0, multi = 0;
        int wb_a = -1, ras_a = -1, cas_a = -1;
        logic [7:0] exp_d, got_d;
        string ktag;
        got_d = 8'h00;
        if (m_open && m_row == a[3:2]) begin
            exp_wb = 0; exp_ras = 0; exp_cas = 1; exp_lat = 3; ktag = "R4";
        end else if (m_open) begin
            exp_wb = 1; exp_ras = 2; exp_cas = 4; exp_lat = 6; ktag = "R5";
        end else begin
            exp_wb = 0; exp_ras = 1; exp_cas = 3; exp_lat = 5; ktag = "R1 R3";
        end
        exp_d = we ? wd : m_mem[a];
        @(negedge clk);
        chk("R10 ready before request", int'(req_ready), 1);
        req_addr   = a;
        req_we     = we;
        req_wdata  = wd;
        req_valid  = 1'b1;
        resp_ready = (hold == 0);
        @(posedge clk);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (int'(mem_ras) + int'(mem_cas) + int'(mem_wb) > 1) multi++;
            if (mem_wb  && got_wb  == 0) begin got_wb  = k; wb_a  = mem_addr; end
            if (mem_ras && got_ras == 0) begin got_ras = k; ras_a = mem_addr; end
            if (mem_cas && got_cas == 0) begin got_cas = k; cas_a = mem_addr; end
            if (resp_valid) begin got_lat = k; got_d = resp_data; break; end
        end
        chk({ktag, " write-back cycle"}, got_wb, exp_wb);
        chk({ktag, " row strobe cycle"}, got_ras, exp_ras);
        chk({ktag, " column strobe cycle"}, got_cas, exp_cas);
        chk({ktag, " response cycle"}, got_lat, exp_lat);
        chk("R2 column on bus", cas_a, int'(a[1:0]));
        if (exp_ras != 0) chk("R2 row on bus", ras_a, int'(a[3:2]));
        if (exp_wb  != 0) chk("R2 closed row on bus", wb_a, int'(m_row));
        chk(dtag, int'(got_d), int'(exp_d));
        chk("R11 single strobe", multi, 0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R9 response held", int'(resp_valid), 1);
            chk("R9 data stable", int'(resp_data), int'(got_d));
        end
        if (hold > 0) resp_ready = 1'b1;
        if (we) m_mem[a] = wd;
        m_open = 1'b1;
        m_row  = a[3:2];
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 no response after reset", int'(resp_valid), 0);
        chk("R1 no strobes after reset", int'(mem_ras) + int'(mem_cas) + int'(mem_wb), 0);
    endtask

    task automatic t_cold_read;
        do_req(4'h6, 1'b0, 8'h00, 0, "R6 cold read data");
    endtask

    task automatic t_hit_reads;
        do_req(4'h4, 1'b0, 8'h00, 0, "R6 hit read data");
        do_req(4'h7, 1'b0, 8'h00, 0, "R6 hit read data");
        do_req(4'h5, 1'b0, 8'h00, 0, "R6 hit read data");
    endtask

    task automatic t_conflict;
        do_req(4'hB, 1'b0, 8'h00, 0, "R6 conflict read data");
        do_req(4'h0, 1'b0, 8'h00, 0, "R6 conflict read data");
    endtask

    task automatic t_write;
        do_req(4'h2, 1'b1, 8'h5A, 0, "R7 write response");
        do_req(4'h2, 1'b0, 8'h00, 0, "R7 read after write");
        do_req(4'h3, 1'b1, 8'hC3, 0, "R7 write response");
    endtask

    task automatic t_writeback;
        do_req(4'hE, 1'b0, 8'h00, 0, "R6 other row read");
        do_req(4'h2, 1'b0, 8'h00, 0, "R8 reopened row data");
        do_req(4'h3, 1'b0, 8'h00, 0, "R8 reopened row data");
    endtask

    task automatic t_backpressure;
        do_req(4'h1, 1'b0, 8'h00, 3, "R9 stalled read data");
    endtask

    // R10: second request taken in the cycle the first response leaves.
    task automatic t_back_to_back;
        int ka = 0, kb = 0, rdy_at_a = 0;
        logic [7:0] da, db;
        da = 8'h00; db = 8'h00;
        @(negedge clk);
        req_addr   = 4'h0;
        req_we     = 1'b0;
        req_wdata  = 8'h00;
        req_valid  = 1'b1;
        resp_ready = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_addr  = 4'h3;
                req_valid = 1'b1;
            end
            if (ka != 0 && k == ka + 1) req_valid = 1'b0;
            if (ka != 0 && k > ka && resp_valid) begin
                kb = k; db = resp_data; break;
            end
            if (ka == 0 && resp_valid) begin
                ka = k; da = resp_data; rdy_at_a = int'(req_ready);
            end
        end
        chk("R10 first response cycle", ka, 3);
        chk("R10 first response data", int'(da), int'(m_mem[0]));
        chk("R10 ready during handoff", rdy_at_a, 1);
        chk("R10 second response cycle", kb, ka + 3);
        chk("R10 second response data", int'(db), int'(m_mem[3]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = 8'(i * 29 + 5);
        m_open     = 1'b0;
        m_row      = 2'd0;
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_addr   = 4'h0;
        req_we     = 1'b0;
        req_wdata  = 8'h00;
        resp_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cold_read();
        t_hit_reads();
        t_conflict();
        t_write();
        t_writeback();
        t_backpressure();
        t_back_to_back();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule